// File: doc/BRIEF.md
# Parallel Program Load Cycle Controller

This block runs the parallel load mode of an on-chip nonvolatile RAM. A programmer outside the chip drives a strobe, a programming-voltage flag, three cycle-select bits, a 15-bit address and a data byte. From these the block chooses one of four actions: write to memory, read a byte back for verification, write a configuration or key register, or set the security lock. It measures each strobe against the width that its cycle type needs, and only then commits the write. It holds the verify output back until the address has been stable for the access time of the selected mode.

The first accepted strobe after reset also sets up a default memory layout: an 8 kbyte range, with the lowest 4 kbytes holding program and the next 4 kbytes holding data. This lets an old 4 kbyte image load without any preparation. The memory array is outside this block. The block drives a write strobe with address and data, and it takes the read byte back from a port that has a one-cycle latency. The memory side accepts a write in every cycle, so no stream on this block carries back-pressure, and every pin is a plain level or pulse.

Top module: `ppl_top`

## Requirements
- R1: After reset, mem_we, vfy_oe and sec_lock are 0, and cfg and key_out are all zero.
- R2: The cycle type comes from hsel[2:0]. 11x sets the security lock. 010 selects expanded memory. 011 selects the registers. 10x selects normal memory. 000 and 001 select no cycle, and a strobe with these values has no effect.
- R3: A program cycle is prog_n low while vpp_on is 1. On the rising edge of prog_n, a memory cycle whose low time is at least 48 clocks (normal) or 1800 clocks (expanded) produces a single one-cycle mem_we pulse that carries the address and data sampled when the strobe fell.
- R4: A strobe that is shorter than the width its cycle type needs writes nothing.
- R5: A normal memory cycle uses only addr[11:0] and drives mem_addr[14:12] to zero. An expanded cycle uses all 15 address bits.
- R6: The first program or security strobe after reset sets cfg[7:4]=1 (program region of 4 kbytes) and cfg[3]=0 (8 kbyte range). This happens when the strobe starts, even if the strobe is later aborted. Later strobes never repeat it.
- R7: A verify cycle needs prog_n high, vpp_on 0 and a memory or register type. vfy_oe rises only after the address, select and mode have stayed steady for at least 48 clocks (normal and register) or 2400 clocks (expanded). It is 0 in every other state.
- R8: When vfy_oe is 1 and the type is memory, vfy_data shows the byte stored at the mapped address.
- R9: A register write takes effect only when addr[14:8] is 0. Low byte 0x10 writes cfg. Low bytes 0x20 to 0x24 write key bytes 0 to 4, and key byte k sits at key_out[8k+7:8k]. Any other address is ignored.
- R10: A register verify at 0x10 returns cfg. Every other register address, including the keys, returns 0xFF.
- R11: cfg[0] is the security lock and drives sec_lock. A security-set cycle of at least 48 clocks sets it. Once set, it stays set until reset, including across cfg writes that have bit 0 clear.
- R12: While sec_lock is 1, memory verify cycles return 0xFF.
- R13: A strobe with vpp_on at 0 writes nothing and does not trigger the layout set-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| prog_n | input | 1 | Active-low program strobe |
| vpp_on | input | 1 | Programming voltage present |
| hsel | input | 3 | Cycle-type select bits |
| addr | input | 15 | Byte or register address |
| din | input | 8 | Byte to program |
| mem_rdata | input | 8 | Read byte from memory, one cycle after mem_addr |
| mem_we | output | 1 | One-cycle memory write pulse |
| mem_addr | output | 15 | Mapped memory address |
| mem_wdata | output | 8 | Byte to write |
| vfy_oe | output | 1 | Verify data valid |
| vfy_data | output | 8 | Verify byte (0 when vfy_oe is low) |
| sec_lock | output | 1 | Security lock state |
| cfg | output | 8 | Configuration register |
| key_out | output | 40 | Five key bytes, byte 0 in the low bits |

## Verification
The checker assumes that the programmer keeps hsel, addr and din steady for the whole of a strobe. It also assumes that vpp_on does not change in the cycle in which prog_n rises, so that the write pulse can never coincide with a verify window. The bench always changes inputs on the falling clock edge and holds them for the full strobe. Before each verify it parks the block for two cycles with vpp_on raised, so that every verify window starts from a clean count. The random strobe lengths fall on both sides of the 48-clock limit.

// File: rtl/ppl_pkg.sv
package ppl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    CY_NONE,
    CY_SEC,
    CY_MEMX,
    CY_MEMN,
    CY_REG
  } cyc_e;
endpackage

// File: rtl/ppl_decode.sv
module ppl_decode
  import ppl_pkg::*;
(
  input  logic [2:0] sel,
  output cyc_e       cyc
);
  always_comb begin
    if (sel[2:1] == 2'b11)      cyc = CY_SEC;
    else if (sel == 3'b010)     cyc = CY_MEMX;
    else if (sel == 3'b011)     cyc = CY_REG;
    else if (sel[2:1] == 2'b10) cyc = CY_MEMN;
    else                        cyc = CY_NONE;
  end
endmodule

// File: rtl/ppl_strobe.sv
module ppl_strobe
  import ppl_pkg::*;
#(
  parameter int NORM_PW = 48,
  parameter int EXP_PW  = 1800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  input  logic vpp,
  input  cyc_e cyc,
  output logic start,
  output logic commit,
  output cyc_e held
);
  localparam int CW = $clog2(EXP_PW + 1);
  localparam logic [CW-1:0] CMAX = '1;

  logic          prev_n;
  logic          active;
  logic [CW-1:0] cnt;
  logic [CW-1:0] need;

  assign start  = prev_n && !prog_n && vpp && (cyc != CY_NONE);
  assign need   = (held == CY_MEMX) ? CW'(EXP_PW) : CW'(NORM_PW);
  assign commit = active && !prev_n && prog_n && (cnt >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= 1'b1;
      active <= 1'b0;
      cnt    <= '0;
      held   <= CY_NONE;
    end else begin
      prev_n <= prog_n;
      if (start) begin
        active <= 1'b1;
        held   <= cyc;
        cnt    <= CW'(1);
      end else if (active) begin
        if (prog_n || !vpp) active <= 1'b0;
        else if (cnt != CMAX) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ppl_vwait.sv
module ppl_vwait #(
  parameter int AW      = 15,
  parameter int NORM_VW = 48,
  parameter int EXP_VW  = 2400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          xp,
  input  logic [AW-1:0] a,
  input  logic [2:0]    s,
  output logic          ready
);
  localparam int VW = $clog2(EXP_VW + 1);
  localparam logic [VW-1:0] VMAX = '1;

  logic [VW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [2:0]    s_q;
  logic          moved;

  assign moved = (a != a_q) || (s != s_q);
  assign ready = act && (cnt >= (xp ? VW'(EXP_VW) : VW'(NORM_VW)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      a_q <= '0;
      s_q <= '0;
    end else begin
      a_q <= a;
      s_q <= s;
      if (!act || moved)    cnt <= '0;
      else if (cnt != VMAX) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ppl_top.sv
module ppl_top
  import ppl_pkg::*;
#(
  parameter int AW       = 15,
  parameter int BANK_W   = 12,
  parameter int NORM_PW  = 48,
  parameter int EXP_PW   = 1800,
  parameter int NORM_VW  = 48,
  parameter int EXP_VW   = 2400,
  parameter int KEY_N    = 5,
  parameter logic [7:0] CFG_REG  = 8'h10,
  parameter logic [7:0] KEY_BASE = 8'h20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    prog_n,
  input  logic                    vpp_on,
  input  logic [2:0]              hsel,
  input  logic [AW-1:0]           addr,
  input  logic [BYTE_W-1:0]       din,
  input  logic [BYTE_W-1:0]       mem_rdata,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [BYTE_W-1:0]       mem_wdata,
  output logic                    vfy_oe,
  output logic [BYTE_W-1:0]       vfy_data,
  output logic                    sec_lock,
  output logic [BYTE_W-1:0]       cfg,
  output logic [KEY_N*BYTE_W-1:0] key_out
);
  localparam int HI_W = AW - 8;

  logic              s_prog_n, s_vpp;
  logic [2:0]        s_sel;
  logic [AW-1:0]     s_addr, w_addr;
  logic [BYTE_W-1:0] s_din, w_din;
  cyc_e              vcyc, hcyc;
  logic              stb_start, stb_commit, init_done;
  logic              v_act, v_xp, v_ready, v_is_reg, w_reg_ok, v_cfg_hit;
  logic [BYTE_W-1:0] key_q [KEY_N];

  function automatic logic [AW-1:0] map_addr(input cyc_e c, input logic [AW-1:0] a);
    if (c == CY_MEMN) return {{(AW-BANK_W){1'b0}}, a[BANK_W-1:0]};
    return a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prog_n <= 1'b1;
      s_vpp    <= 1'b0;
      s_sel    <= '0;
      s_addr   <= '0;
      s_din    <= '0;
    end else begin
      s_prog_n <= prog_n;
      s_vpp    <= vpp_on;
      s_sel    <= hsel;
      s_addr   <= addr;
      s_din    <= din;
    end
  end

  ppl_decode u_dec (.sel(s_sel), .cyc(vcyc));

  ppl_strobe #(.NORM_PW(NORM_PW), .EXP_PW(EXP_PW)) u_stb (
    .clk(clk), .rst_n(rst_n), .prog_n(s_prog_n), .vpp(s_vpp), .cyc(vcyc),
    .start(stb_start), .commit(stb_commit), .held(hcyc)
  );

  assign v_act    = s_prog_n && !s_vpp && (vcyc != CY_NONE) && (vcyc != CY_SEC);
  assign v_xp     = (vcyc == CY_MEMX);
  assign v_is_reg = (vcyc == CY_REG);

  ppl_vwait #(.AW(AW), .NORM_VW(NORM_VW), .EXP_VW(EXP_VW)) u_vw (
    .clk(clk), .rst_n(rst_n), .act(v_act), .xp(v_xp), .a(s_addr), .s(s_sel),
    .ready(v_ready)
  );

  // Capture address and data at the falling strobe edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_addr <= '0;
      w_din  <= '0;
    end else if (stb_start) begin
      w_addr <= s_addr;
      w_din  <= s_din;
    end
  end

  // Memory port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= stb_commit && (hcyc == CY_MEMN || hcyc == CY_MEMX);
      mem_wdata <= w_din;
      mem_addr  <= stb_commit ? map_addr(hcyc, w_addr) : map_addr(vcyc, s_addr);
    end
  end

  assign w_reg_ok = (hcyc == CY_REG) && (w_addr[AW-1:8] == {HI_W{1'b0}});

  // Configuration register, layout set-up and lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      init_done <= 1'b0;
    end else begin
      if (stb_start && !init_done) begin
        cfg[7:3]  <= 5'b0001_0;
        init_done <= 1'b1;
      end
      if (stb_commit) begin
        if (hcyc == CY_SEC) cfg[0] <= 1'b1;
        else if (w_reg_ok && w_addr[7:0] == CFG_REG)
          cfg <= {w_din[7:1], w_din[0] | cfg[0]};
      end
    end
  end

  for (genvar k = 0; k < KEY_N; k++) begin : g_key
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q[k] <= '0;
      else if (stb_commit && w_reg_ok && w_addr[7:0] == 8'(KEY_BASE + k))
        key_q[k] <= w_din;
    end
    assign key_out[k*BYTE_W +: BYTE_W] = key_q[k];
  end

  assign sec_lock  = cfg[0];
  assign vfy_oe    = v_ready;
  assign v_cfg_hit = (s_addr[AW-1:8] == {HI_W{1'b0}}) && (s_addr[7:0] == CFG_REG);

  always_comb begin
    if (!v_ready)      vfy_data = '0;
    else if (v_is_reg) vfy_data = v_cfg_hit ? cfg : 8'hFF;
    else if (cfg[0])   vfy_data = 8'hFF;
    else               vfy_data = mem_rdata;
  end
endmodule

// File: rtl/ppl_chk.sv
module ppl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_we,
  input logic       vfy_oe,
  input logic       sec_lock,
  input logic [7:0] vfy_data,
  input logic       v_is_reg,
  input logic       init_done
);
  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_lock |=> sec_lock);
  // R12
  locked_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_lock && vfy_oe && !v_is_reg) |-> vfy_data == 8'hFF);
  // R7
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !vfy_oe);
  // R6
  init_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> init_done);
endmodule

bind ppl_top ppl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .vfy_oe(vfy_oe),
  .sec_lock(sec_lock), .vfy_data(vfy_data), .v_is_reg(v_is_reg),
  .init_done(init_done)
);

// File: tb/ppl_top_tb.sv
module ppl_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_n = 1'b1, vpp_on = 1'b0;
  logic [2:0]  hsel = 3'b000;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0, mem_rdata = '0;
  logic        mem_we, vfy_oe, sec_lock;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata, vfy_data, cfg;
  logic [39:0] key_out;

  int nvec = 0, nfail = 0, we_cnt = 0;
  bit done = 0;
  logic [7:0] mem_model [int];
  logic [7:0] exp_mem [int];

  always #2.5 clk = ~clk;

  ppl_top u_dut (.*);

  function automatic logic [7:0] rd_model(input int a);
    return mem_model.exists(a) ? mem_model[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      mem_model[int'(mem_addr)] = mem_wdata;
      we_cnt++;
    end
    mem_rdata <= rd_model(int'(mem_addr));
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic strobe(input logic [2:0] s, input logic [14:0] a, input logic [7:0] d,
                        input int len, input logic v);
    @(negedge clk);
    hsel = s; addr = a; din = d; vpp_on = v;
    @(negedge clk);
    prog_n = 1'b0;
    repeat (len) @(negedge clk);
    prog_n = 1'b1;
    repeat (6) @(negedge clk);
    vpp_on = 1'b0;
  endtask

  task automatic verify(input logic [2:0] s, input logic [14:0] a, input int w,
                        input logic [7:0] expv, input string req);
    @(negedge clk);
    vpp_on = 1'b1; prog_n = 1'b1;
    repeat (2) @(negedge clk);
    vpp_on = 1'b0; hsel = s; addr = a;
    repeat (w - 1) @(negedge clk);
    chk(vfy_oe == 1'b0, {req, " early oe"}, vfy_oe, 0);
    repeat (5) @(negedge clk);
    chk(vfy_oe == 1'b1, {req, " oe"}, vfy_oe, 1);
    chk(vfy_data == expv, {req, " data"}, vfy_data, expv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int base;
    logic [14:0] alist [40];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_we == 0 && vfy_oe == 0 && sec_lock == 0, "R1 flags", {mem_we, vfy_oe, sec_lock}, 0);
    chk(cfg == 8'h00, "R1 cfg", cfg, 0);
    chk(key_out == '0, "R1 key", key_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R13 no programming voltage
    strobe(3'b100, 15'h0005, 8'h77, 60, 1'b0);
    chk(we_cnt == 0, "R13 no write", we_cnt, 0);
    chk(cfg == 8'h00, "R13 no setup", cfg, 0);

    // R2 unused select codes
    strobe(3'b000, 15'h0006, 8'h66, 60, 1'b1);
    strobe(3'b001, 15'h0006, 8'h66, 60, 1'b1);
    chk(we_cnt == 0, "R2 idle code", we_cnt, 0);
    chk(cfg == 8'h00, "R2 idle code cfg", cfg, 0);

    // R4 short first strobe, R6 set-up on start
    strobe(3'b100, 15'h0005, 8'h55, 47, 1'b1);
    chk(we_cnt == 0, "R4 short normal", we_cnt, 0);
    chk(cfg == 8'h10, "R6 setup", cfg, 8'h10);

    // R3 exact width, R5 normal mapping
    strobe(3'b101, 15'h7ABC, 8'h3C, 48, 1'b1);
    chk(we_cnt == 1, "R3 write count", we_cnt, 1);
    chk(rd_model(32'h0ABC) == 8'h3C, "R5 normal map", rd_model(32'h0ABC), 8'h3C);
    exp_mem[32'h0ABC] = 8'h3C;
    verify(3'b100, 15'h0ABC, 48, 8'h3C, "R8 normal verify");

    // Random normal writes, R3 R4 R5
    base = we_cnt;
    for (int i = 0; i < 40; i++) begin
      logic [14:0] a;
      logic [7:0]  d;
      int len;
      a = 15'($urandom);
      d = 8'($urandom);
      alist[i] = a;
      len = ($urandom % 4 == 0) ? 20 + int'($urandom % 28) : 48 + int'($urandom % 8);
      strobe({2'b10, 1'($urandom)}, a, d, len, 1'b1);
      if (len >= 48) begin
        exp_mem[int'(a[11:0])] = d;
        base++;
      end
      chk(we_cnt == base, "R4 random strobe", we_cnt, base);
    end
    for (int i = 0; i < 40; i++) begin
      logic [14:0] a;
      logic [7:0] e;
      a = {3'($urandom), alist[i][11:0]};
      e = exp_mem.exists(int'(a[11:0])) ? exp_mem[int'(a[11:0])] : 8'h00;
      verify(3'b100, a, 48, e, "R8 random verify");
    end

    // Expanded cycles, R4 R5
    base = we_cnt;
    strobe(3'b010, 15'h5123, 8'h99, 1799, 1'b1);
    chk(we_cnt == base, "R4 short expanded", we_cnt, base);
    strobe(3'b010, 15'h5123, 8'h99, 1800, 1'b1);
    chk(we_cnt == base + 1, "R3 expanded write", we_cnt, base + 1);
    chk(rd_model(32'h5123) == 8'h99, "R5 expanded map", rd_model(32'h5123), 8'h99);
    verify(3'b010, 15'h5123, 2400, 8'h99, "R7 expanded verify");

    // Registers, R9 R10
    for (int k = 0; k < 5; k++)
      strobe(3'b011, 15'(8'h20 + k), 8'(k * 17 + 1), 48, 1'b1);
    chk(key_out == 40'h4534_2312_01, "R9 keys", key_out, 40'h4534_2312_01);
    strobe(3'b011, 15'h0110, 8'hEE, 48, 1'b1);
    strobe(3'b011, 15'h0030, 8'hEE, 48, 1'b1);
    chk(cfg == 8'h10, "R9 bad reg addr cfg", cfg, 8'h10);
    chk(key_out == 40'h4534_2312_01, "R9 bad reg addr key", key_out, 40'h4534_2312_01);
    strobe(3'b011, 15'h0010, 8'h5A, 48, 1'b1);
    chk(cfg == 8'h5A, "R9 cfg write", cfg, 8'h5A);
    verify(3'b011, 15'h0010, 48, 8'h5A, "R10 cfg verify");
    verify(3'b011, 15'h0021, 48, 8'hFF, "R10 key verify");

    // R6 not repeated
    strobe(3'b100, 15'h0100, 8'h42, 48, 1'b1);
    chk(cfg == 8'h5A, "R6 once", cfg, 8'h5A);

    // R11 lock
    strobe(3'b110, 15'h0000, 8'h00, 48, 1'b1);
    chk(sec_lock == 1 && cfg == 8'h5B, "R11 set", cfg, 8'h5B);
    strobe(3'b011, 15'h0010, 8'hA4, 48, 1'b1);
    chk(cfg == 8'hA5, "R11 sticky", cfg, 8'hA5);

    // R12 locked verify
    verify(3'b100, 15'h0ABC, 48, 8'hFF, "R12 locked verify");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule